// File: doc/BRIEF.md
# Fine-Grained System Instruction Trap Evaluator

This unit holds the hypervisor's 64-bit trap-control word. For each decoded system instruction it decides whether execution at EL0 or EL1 must be diverted to EL2. When it diverts, it also reports the exception class code for the syndrome. Each bit of the word is bound to one instruction group. Bits differ in three ways:

- the exception levels they cover;
- whether the host-mode pair (E2H and TGE both set) masks them;
- whether a 32-bit EL0 form exists, and which class code that form reports.

The caller gives the group as a bit index on `instrClass`. It also gives the execution context: the current level, the instruction's state, the EL1 state, the EL2 and EL3 presence and enable flags, and a flag for an exception of higher priority. One cycle after `instrValid`, the unit returns a registered verdict and pulses `outValid`.

Some groups depend on optional features. Parameters say which features are built. A bit that belongs to an absent feature is cleared when the word is written and never causes a trap.

Top module: `fgt_trap_eval`

## Requirements
- R1: After reset the trap word reads as zero, and `outValid`, `trapToEl2` and `trapClass` are all zero.
- R2: A write (`cfgWrEn`) loads `cfgWrData` into the word on the next clock edge and the new value appears on `cfgRdData`. On that write, bits 63..55 are forced to zero. So are the bits of absent features: 41..34 and 27..18 (extended TLB invalidates), 50..48 (prediction restriction), 9 (persistence clean) and 17..16 (privileged translation).
- R3: `outValid` is high in exactly the cycle after a cycle with `instrValid` high. While `outValid` is low, `trapToEl2` and `trapClass` are zero.
- R4: A trap is raised only under both of these conditions:
  - EL2 is present and enabled;
  - EL3 is absent, or the EL3 fine-grained enable is set.
- R5: No trap is raised when `higherPrio` is set.
- R6: Bits 47..12, 6..3, 1 and 0 trap only 64-bit execution at EL1, with class 0x18, whatever E2H and TGE are.
- R7: Bits 54, 11..7 and 2 trap 64-bit execution at EL0 or EL1 with class 0x18. They do not trap when E2H and TGE are both 1.
- R8: Bit 53 traps a supervisor call at EL1 in 64-bit state, with class 0x15.
- R9: Bit 52 traps a supervisor call at EL0, reporting class 0x15 in 64-bit state and 0x11 in 32-bit state. It does so only when E2H and TGE are not both 1 and `el1A64` is 1.
- R10: Bit 51 traps exception-return instructions at EL1 in 64-bit state, with class 0x1A.
- R11: Bits 50..48 trap at EL1 in 64-bit state and at EL0 in either state. They report class 0x03 for the 32-bit EL0 form and 0x18 otherwise. They require E2H and TGE not both 1 and `el1A64` set.
- R12: These cases never trap:
  - an index of 55..63;
  - an index whose word bit is zero;
  - `curEl` of 2 or 3;
  - 32-bit execution for any group other than bits 52 and 50..48.
- R13: An evaluation in the same cycle as a write uses the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load the trap word |
| cfgWrData | input | 64 | Value to load |
| cfgRdData | output | 64 | Current trap word |
| instrValid | input | 1 | An instruction is presented for evaluation |
| instrClass | input | 6 | Bit index of the instruction's trap group |
| curEl | input | 2 | Current exception level |
| instrA32 | input | 1 | 1 = instruction executes in 32-bit state |
| el1A64 | input | 1 | 1 = EL1 runs in 64-bit state |
| el2Present | input | 1 | EL2 implemented |
| el2Enabled | input | 1 | EL2 enabled in the current security state |
| hostE2h | input | 1 | Hypervisor E2H bit |
| hostTge | input | 1 | Hypervisor TGE bit |
| el3Present | input | 1 | EL3 implemented |
| el3FgtEn | input | 1 | EL3 enable for fine-grained traps |
| higherPrio | input | 1 | Instruction already raises a higher-priority exception |
| outValid | output | 1 | Verdict valid this cycle |
| trapToEl2 | output | 1 | Instruction must be taken to EL2 |
| trapClass | output | 6 | Exception class code of the trap, zero when none |

## Verification
A word update and an evaluation can land in the same cycle, and the verdict must then come from the old word. The bench drives `cfgWrEn` and `instrValid` together in one cycle: it enables a trap bit, then clears it in the same cycle that the group is evaluated. It expects the trap to be taken, because the bench model uses the word held before the write. A following evaluation with no write must show no trap, since it reads the cleared word. Randomised runs also write and evaluate together now and then, so the bench model applies each write only after it has scored the evaluation in that cycle.

// File: rtl/fgt_pkg.sv
package fgt_pkg;

  localparam int WORD_W  = 64;
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int TOP_BIT = 54;

  localparam logic [5:0] EC_SYS64  = 6'h18;
  localparam logic [5:0] EC_SVC64  = 6'h15;
  localparam logic [5:0] EC_SVC32  = 6'h11;
  localparam logic [5:0] EC_ERET   = 6'h1A;
  localparam logic [5:0] EC_SYS32  = 6'h03;

  typedef enum logic [2:0] {
    CAT_NONE,
    CAT_EL1,
    CAT_DCVA,
    CAT_SVC1,
    CAT_SVC0,
    CAT_ERET,
    CAT_PRED
  } trap_cat_e;

  typedef struct packed {
    logic loadWord;
    logic capture;
  } ctrl_strobe_t;

  function automatic trap_cat_e catOf(int idx);
    if (idx > TOP_BIT)                        return CAT_NONE;
    if (idx == 53)                            return CAT_SVC1;
    if (idx == 52)                            return CAT_SVC0;
    if (idx == 51)                            return CAT_ERET;
    if (idx >= 48 && idx <= 50)               return CAT_PRED;
    if (idx == 54 || idx == 2 ||
        (idx >= 7 && idx <= 11))              return CAT_DCVA;
    return CAT_EL1;
  endfunction

  function automatic logic [WORD_W-1:0] implMask(bit hasTlbiExt, bit hasPred,
                                                 bit hasPersist, bit hasAtPriv);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b <= TOP_BIT; b++) m[b] = 1'b1;
    if (!hasTlbiExt) begin
      for (int b = 34; b <= 41; b++) m[b] = 1'b0;
      for (int b = 18; b <= 27; b++) m[b] = 1'b0;
    end
    if (!hasPred) m[50:48] = 3'b000;
    if (!hasPersist) m[9] = 1'b0;
    if (!hasAtPriv) m[17:16] = 2'b00;
    return m;
  endfunction

endpackage

// File: rtl/fgt_ctrl.sv
module fgt_ctrl
  import fgt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         instrValid,
  output ctrl_strobe_t strobe,
  output logic         outValid
);

  always_comb begin
    strobe.loadWord = cfgWrEn;
    strobe.capture  = instrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= instrValid;
  end

endmodule

// File: rtl/fgt_datapath.sv
module fgt_datapath
  import fgt_pkg::*;
#(
  parameter int                W       = WORD_W,
  parameter int                IW      = IDX_W,
  parameter logic [WORD_W-1:0] IMPL    = '1
)(
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobe_t  strobe,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  wordQ,
  input  logic [IW-1:0] instrClass,
  input  logic [1:0]    curEl,
  input  logic          instrA32,
  input  logic          el1A64,
  input  logic          el2Present,
  input  logic          el2Enabled,
  input  logic          hostE2h,
  input  logic          hostTge,
  input  logic          el3Present,
  input  logic          el3FgtEn,
  input  logic          higherPrio,
  output logic          trapQ,
  output logic [5:0]    codeQ
);

  logic atEl0, atEl1, inA64, hostMode, gateOk;
  logic [W-1:0] hitVec;
  logic [5:0]   codeVec [W];
  logic         selHit;

  always_comb begin
    atEl0    = (curEl == 2'd0);
    atEl1    = (curEl == 2'd1);
    inA64    = !instrA32;
    hostMode = hostE2h && hostTge;
    gateOk   = el2Present && el2Enabled && (!el3Present || el3FgtEn) && !higherPrio;
  end

  for (genvar b = 0; b < W; b++) begin : g_slot
    localparam trap_cat_e CAT = catOf(b);
    logic levelOk;
    always_comb begin
      levelOk    = 1'b0;
      codeVec[b] = EC_SYS64;
      case (CAT)
        CAT_EL1:  levelOk = atEl1 && inA64;
        CAT_DCVA: levelOk = (atEl0 || atEl1) && inA64 && !hostMode;
        CAT_SVC1: begin
          levelOk    = atEl1 && inA64;
          codeVec[b] = EC_SVC64;
        end
        CAT_SVC0: begin
          levelOk    = atEl0 && !hostMode && el1A64;
          codeVec[b] = instrA32 ? EC_SVC32 : EC_SVC64;
        end
        CAT_ERET: begin
          levelOk    = atEl1 && inA64;
          codeVec[b] = EC_ERET;
        end
        CAT_PRED: begin
          levelOk    = !hostMode && el1A64 && ((atEl1 && inA64) || atEl0);
          codeVec[b] = (atEl0 && instrA32) ? EC_SYS32 : EC_SYS64;
        end
        default:  levelOk = 1'b0;
      endcase
      hitVec[b] = wordQ[b] && levelOk;
    end
  end

  assign selHit = hitVec[instrClass] && gateOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.loadWord) begin
      wordQ <= wrData & IMPL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapQ <= 1'b0;
      codeQ <= '0;
    end else if (strobe.capture) begin
      trapQ <= selHit;
      codeQ <= selHit ? codeVec[instrClass] : 6'h00;
    end else begin
      trapQ <= 1'b0;
      codeQ <= '0;
    end
  end

endmodule

// File: rtl/fgt_trap_eval.sv
module fgt_trap_eval
  import fgt_pkg::*;
#(
  parameter bit HAS_TLBI_EXT      = 1'b1,
  parameter bit HAS_PRED_RESTRICT = 1'b1,
  parameter bit HAS_DC_PERSIST    = 1'b1,
  parameter bit HAS_AT_PRIV       = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  input  logic              instrValid,
  input  logic [IDX_W-1:0]  instrClass,
  input  logic [1:0]        curEl,
  input  logic              instrA32,
  input  logic              el1A64,
  input  logic              el2Present,
  input  logic              el2Enabled,
  input  logic              hostE2h,
  input  logic              hostTge,
  input  logic              el3Present,
  input  logic              el3FgtEn,
  input  logic              higherPrio,
  output logic              outValid,
  output logic              trapToEl2,
  output logic [5:0]        trapClass
);

  localparam logic [WORD_W-1:0] IMPL_MASK =
    implMask(HAS_TLBI_EXT, HAS_PRED_RESTRICT, HAS_DC_PERSIST, HAS_AT_PRIV);

  ctrl_strobe_t strobe;

  fgt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .instrValid (instrValid),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  fgt_datapath #(.W(WORD_W), .IW(IDX_W), .IMPL(IMPL_MASK)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (cfgWrData),
    .wordQ      (cfgRdData),
    .instrClass (instrClass),
    .curEl      (curEl),
    .instrA32   (instrA32),
    .el1A64     (el1A64),
    .el2Present (el2Present),
    .el2Enabled (el2Enabled),
    .hostE2h    (hostE2h),
    .hostTge    (hostTge),
    .el3Present (el3Present),
    .el3FgtEn   (el3FgtEn),
    .higherPrio (higherPrio),
    .trapQ      (trapToEl2),
    .codeQ      (trapClass)
  );

endmodule

// File: rtl/fgt_trap_eval_chk.sv
module fgt_trap_eval_chk
  import fgt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [IDX_W-1:0]  instrClass,
  input logic [1:0]        curEl,
  input logic              el2Present,
  input logic              el2Enabled,
  input logic              el3Present,
  input logic              el3FgtEn,
  input logic              higherPrio,
  input logic              outValid,
  input logic              trapToEl2,
  input logic [5:0]        trapClass
);

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> outValid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> !outValid);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!trapToEl2 && trapClass == 6'h00));
  a_r4_el2_gate: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !(el2Present && el2Enabled)) |=> !trapToEl2);
  a_r4_el3_gate: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && el3Present && !el3FgtEn) |=> !trapToEl2);
  a_r5_priority: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && higherPrio) |=> !trapToEl2);
  a_r12_high_level: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && curEl[1]) |=> !trapToEl2);
  a_r12_reserved_index: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrClass > IDX_W'(TOP_BIT)) |=> !trapToEl2);
  a_r8_class_legal: assert property (@(posedge clk) disable iff (!rstN)
    trapToEl2 |-> (trapClass == EC_SYS64 || trapClass == EC_SVC64 ||
                   trapClass == EC_SVC32 || trapClass == EC_ERET ||
                   trapClass == EC_SYS32));

endmodule

bind fgt_trap_eval fgt_trap_eval_chk u_chk (.*);

// File: tb/fgt_trap_eval_tb.sv
module fgt_trap_eval_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [63:0] cfgWrData = '0;
  logic [63:0] cfgRdData;
  logic        instrValid = 1'b0;
  logic [5:0]  instrClass = '0;
  logic [1:0]  curEl = 2'd1;
  logic        instrA32 = 1'b0, el1A64 = 1'b1;
  logic        el2Present = 1'b1, el2Enabled = 1'b1;
  logic        hostE2h = 1'b0, hostTge = 1'b0;
  logic        el3Present = 1'b0, el3FgtEn = 1'b0, higherPrio = 1'b0;
  logic        outValid, trapToEl2;
  logic [5:0]  trapClass;

  int total = 0;
  int bad = 0;
  logic [63:0] shadow = '0;

  always #2.5 clk = ~clk;

  // built with extended TLB invalidates and persistence clean absent
  fgt_trap_eval #(.HAS_TLBI_EXT(1'b0), .HAS_PRED_RESTRICT(1'b1),
                  .HAS_DC_PERSIST(1'b0), .HAS_AT_PRIV(1'b1)) u_dut (.*);

  function automatic logic [63:0] benchMask();
    logic [63:0] m = '0;
    for (int b = 0; b <= 54; b++)
      if (!((b >= 34 && b <= 41) || (b >= 18 && b <= 27) || b == 9)) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [6:0] model(logic [63:0] w, int c);
    logic host = hostE2h && hostTge;
    logic t = 1'b0;
    logic [5:0] k = 6'h18;
    if (!(el2Present && el2Enabled && (!el3Present || el3FgtEn) && !higherPrio)) return 7'd0;
    if (c > 54 || !w[c]) return 7'd0;
    if (c == 53) begin t = curEl == 1 && !instrA32; k = 6'h15; end
    else if (c == 52) begin t = curEl == 0 && !host && el1A64; k = instrA32 ? 6'h11 : 6'h15; end
    else if (c == 51) begin t = curEl == 1 && !instrA32; k = 6'h1A; end
    else if (c >= 48 && c <= 50) begin
      t = !host && el1A64 && ((curEl == 1 && !instrA32) || curEl == 0);
      k = (curEl == 0 && instrA32) ? 6'h03 : 6'h18;
    end
    else if (c == 54 || c == 2 || (c >= 7 && c <= 11))
      t = curEl <= 1 && !instrA32 && !host;
    else t = curEl == 1 && !instrA32;
    return t ? {1'b1, k} : 7'd0;
  endfunction

  function automatic string tagOf(int c);
    if (c > 54) return "R12";
    if (c == 53) return "R8";
    if (c == 52) return "R9";
    if (c == 51) return "R10";
    if (c >= 48 && c <= 50) return "R11";
    if (c == 54 || c == 2 || (c >= 7 && c <= 11)) return "R7";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeWord(logic [63:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    shadow = d & benchMask();
  endtask

  task automatic evalCheck(int c, string tag, bit alsoWrite = 1'b0, logic [63:0] d = '0);
    logic [6:0] exp;
    @(negedge clk);
    instrValid = 1'b1; instrClass = 6'(c);
    if (alsoWrite) begin cfgWrEn = 1'b1; cfgWrData = d; end
    exp = model(shadow, c);
    @(posedge clk); #1;
    if (alsoWrite) begin cfgWrEn = 1'b0; shadow = d & benchMask(); end
    chk(outValid == 1'b1, "R3", 64'(outValid), 64'd1);
    chk({trapToEl2, trapClass} == exp, tag, 64'({trapToEl2, trapClass}), 64'(exp));
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic ctx(int el, bit a32, bit e1a64, bit h);
    curEl = 2'(el); instrA32 = a32; el1A64 = e1a64; hostE2h = h; hostTge = h;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    // R1 reset state
    chk(cfgRdData == 64'd0, "R1", cfgRdData, 64'd0);
    chk(!outValid && !trapToEl2 && trapClass == 0, "R1",
        64'({outValid, trapToEl2, trapClass}), 64'd0);
    // R2 masking on write
    writeWord('1);
    chk(cfgRdData == benchMask(), "R2", cfgRdData, benchMask());

    ctx(1, 0, 1, 0);
    evalCheck(45, "R6");
    ctx(0, 0, 1, 0); evalCheck(45, "R6");
    ctx(1, 0, 1, 1); evalCheck(45, "R6");
    ctx(0, 0, 1, 0); evalCheck(10, "R7");
    ctx(0, 0, 1, 1); evalCheck(10, "R7");
    ctx(1, 0, 1, 0); evalCheck(53, "R8");
    ctx(0, 0, 1, 0); evalCheck(53, "R8");
    ctx(0, 0, 1, 0); evalCheck(52, "R9");
    ctx(0, 1, 1, 0); evalCheck(52, "R9");
    ctx(0, 1, 0, 0); evalCheck(52, "R9");
    ctx(1, 0, 1, 0); evalCheck(51, "R10");
    ctx(0, 1, 1, 0); evalCheck(49, "R11");
    ctx(1, 0, 1, 0); evalCheck(49, "R11");
    ctx(1, 1, 1, 0); evalCheck(12, "R12");
    ctx(1, 0, 1, 0);
    evalCheck(60, "R12"); evalCheck(40, "R12"); evalCheck(9, "R12");
    ctx(2, 0, 1, 0); evalCheck(45, "R12");
    ctx(1, 0, 1, 0);
    el2Enabled = 1'b0; evalCheck(45, "R4"); el2Enabled = 1'b1;
    el3Present = 1'b1; evalCheck(45, "R4");
    el3FgtEn = 1'b1;   evalCheck(45, "R4");
    el3Present = 1'b0; el3FgtEn = 1'b0;
    higherPrio = 1'b1; evalCheck(45, "R5"); higherPrio = 1'b0;
    // R3 idle cycle after a verdict
    @(posedge clk); #1;
    chk(!outValid && !trapToEl2 && trapClass == 0, "R3",
        64'({outValid, trapToEl2, trapClass}), 64'd0);
    // R13 write and evaluate together: old word decides
    evalCheck(45, "R13", 1'b1, 64'd0);
    evalCheck(45, "R13");

    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 0) writeWord({$urandom, $urandom});
      curEl      = 2'($urandom % 4);
      instrA32   = ($urandom % 4) == 0;
      el1A64     = ($urandom % 6) != 0;
      el2Present = ($urandom % 10) != 0;
      el2Enabled = ($urandom % 10) != 0;
      hostE2h    = ($urandom % 3) == 0;
      hostTge    = ($urandom % 3) == 0;
      el3Present = $urandom % 2;
      el3FgtEn   = ($urandom % 4) != 0;
      higherPrio = ($urandom % 10) == 0;
      if (i % 11 == 5) begin
        int c = int'($urandom % 64);
        evalCheck(c, "R13", 1'b1, {$urandom, $urandom});
      end else begin
        int c = int'($urandom % 64);
        evalCheck(c, tagOf(c));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule